// File: doc/BRIEF.md
# Serial Equalizer Settings Receiver

This block is the digital control front end of a four-band stereo parametric equalizer. A host drives three serial lines: a frame strobe, a serial clock and serial data. These lines are brought into the system clock domain. An 8-bit device address is shifted in while the strobe is low. Twenty data bits are shifted in while the strobe is high. When the strobe falls, the frame is checked. If it passes, its fields are committed to a bank of setting registers. The bank holds one set of registers for each channel (left and right) and each band (low, low-mid, high-mid, high).

Each band register holds a center-frequency code, a gain code and a Q code. Each channel also holds a low-band response mode, which is either peaking or shelving. One global flag doubles the center frequency of every band. The outputs are the registered settings that would steer the analog switch selects. Nothing changes on the outputs between commits.

The design is a three-state controller. In COLLECT_ADDR the block shifts address bits. It moves to COLLECT_DATA on a strobe rise, which also captures whether the address matched. In COLLECT_DATA it shifts data bits and counts them. It moves to COMMIT on a strobe fall. COMMIT lasts one cycle: it raises the write enable if the frame is valid and then returns to COLLECT_ADDR.

Top module: `eq_ctl_top`

## Requirements
- R1: After reset, every band of both channels holds frequency code 0, gain code 6 (flat), Q code 0 (Q1), and the low band is in peaking mode (shelf bit 0). The doubling flag is 0.
- R2: Address bits are shifted LSB first on serial clock rises while the strobe is low. Data bits D0..D19 are shifted LSB first on serial clock rises while the strobe is high. Outputs change only after the strobe falls, never while data is still being shifted.
- R3: A frame whose 8 address bits differ from the DEV_ADDR parameter leaves every output unchanged.
- R4: A frame carrying fewer or more than exactly 20 data bits when the strobe falls leaves every output unchanged.
- R5: Channel select is {D2,D1}: D1 targets left and D2 targets right, so 01 selects left, 10 selects right and 11 selects both. With 00, no band register is written.
- R6: Band select is {D5,D4,D3}: 010 selects low with peaking, 011 low with shelving, 100 low-mid, 101 high-mid and 110 high. Writing the low band sets that channel's shelf bit to 1 for shelving and to 0 for peaking.
- R7: A valid band frame stores frequency D9:D6, gain D13:D10 and Q D16:D14 into the selected band of the selected channels only. D19:D17 are ignored. Output slice (ch*4+band) of freq_o/gain_o (4 bits) and q_o (3 bits) holds the setting, where ch 0 is left and bands 0..3 are low, low-mid, high-mid and high.
- R8: A band frame with a frequency code above 10 or a gain code above 12 is discarded as a whole, including its doubling bit.
- R9: Every accepted frame loads D0 into the doubling flag. When {D5,D4} is 00, only the flag is updated and all other data bits are ignored, even out-of-range codes.
- R10: Band select 111 is reserved, and such a frame is discarded as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Frame strobe (low: address phase, high: data phase, fall: commit) |
| sclk_i | input | 1 | Serial clock, sampled on its rise |
| sdi_i | input | 1 | Serial data |
| freq_o | output | 32 | Frequency codes, 4 bits per channel/band entry |
| gain_o | output | 32 | Gain codes, 4 bits per entry, 6 is flat |
| q_o | output | 24 | Q codes, 3 bits per entry |
| shelf_o | output | 2 | Low-band shelving mode, bit 0 left, bit 1 right |
| dbl_o | output | 1 | Global frequency-doubling flag |

## Verification
The assertions assume that the serial lines change slowly relative to the system clock. Each line must hold a value for several system cycles, so the strobe stays low throughout the one-cycle COMMIT window. Data must also be stable around each serial clock rise, after it has passed through the two-flop synchronizers. The bench keeps every serial level for four system cycles before and after each serial clock transition. It also leaves idle cycles around each strobe edge, so no strobe edge coincides with a serial clock edge.

// File: rtl/eq_ctl_pkg.sv
package eq_ctl_pkg;

    localparam int NUM_CH    = 2;
    localparam int NUM_BAND  = 4;
    localparam int BAND_W    = $clog2(NUM_BAND);
    localparam int FREQ_W    = 4;
    localparam int GAIN_W    = 4;
    localparam int Q_W       = 3;
    localparam int ADDR_BITS = 8;
    localparam int DATA_BITS = 20;
    localparam int FREQ_MAX  = 10;
    localparam int GAIN_MAX  = 12;
    localparam int GAIN_FLAT = 6;

    typedef enum logic [1:0] {
        COLLECT_ADDR = 2'd0,
        COLLECT_DATA = 2'd1,
        COMMIT       = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic                dbl;
        logic                dbl_only;
        logic [NUM_CH-1:0]   ch;
        logic [BAND_W-1:0]   band;
        logic                shelf;
        logic [FREQ_W-1:0]   freq;
        logic [GAIN_W-1:0]   gain;
        logic [Q_W-1:0]      q;
    } eq_cmd_t;

endpackage

// File: rtl/eq_ctl_sync.sv
module eq_ctl_sync #(
    parameter int LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end
        assign sync_o[i] = stab_q;
    end

endmodule

// File: rtl/eq_ctl_deframer.sv
module eq_ctl_deframer
    import eq_ctl_pkg::*;
#(
    parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h82
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce,
    input  logic      sclk,
    input  logic      sdi,
    output logic      wr_en,
    output eq_cmd_t   cmd
);

    localparam int CNT_W = $clog2(DATA_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    rx_state_t             state_q, state_d;
    logic                  ce_q, sclk_q;
    logic                  ce_rise, ce_fall, sclk_rise;
    logic [ADDR_BITS-1:0]  addr_sr;
    logic [DATA_BITS-1:0]  data_sr;
    logic [CNT_W-1:0]      cnt_q;
    logic                  addr_ok_q;

    logic [2:0]            bsel;
    logic                  band_bad;
    logic                  fields_ok;

    assign ce_rise   =  ce & ~ce_q;
    assign ce_fall   = ~ce &  ce_q;
    assign sclk_rise =  sclk & ~sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= COLLECT_ADDR;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            COLLECT_ADDR: if (ce_rise) state_d = COLLECT_DATA;
            COLLECT_DATA: if (ce_fall) state_d = COMMIT;
            COMMIT:                    state_d = COLLECT_ADDR;
            default:                   state_d = COLLECT_ADDR;
        endcase
    end

    // shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q      <= 1'b0;
            sclk_q    <= 1'b0;
            addr_sr   <= '0;
            data_sr   <= '0;
            cnt_q     <= '0;
            addr_ok_q <= 1'b0;
        end else begin
            ce_q   <= ce;
            sclk_q <= sclk;
            unique case (state_q)
                COLLECT_ADDR: begin
                    if (ce_rise) begin
                        addr_ok_q <= (addr_sr == DEV_ADDR);
                        cnt_q     <= '0;
                    end else if (sclk_rise) begin
                        addr_sr <= {sdi, addr_sr[ADDR_BITS-1:1]};
                    end
                end
                COLLECT_DATA: begin
                    if (sclk_rise) begin
                        data_sr <= {sdi, data_sr[DATA_BITS-1:1]};
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end
                end
                COMMIT: begin
                    addr_sr <= '0;
                end
                default: ;
            endcase
        end
    end

    // field decode
    assign bsel = data_sr[5:3];

    always_comb begin
        cmd          = '0;
        cmd.dbl      = data_sr[0];
        cmd.ch       = data_sr[2:1];
        cmd.dbl_only = (bsel[2:1] == 2'b00);
        cmd.freq     = data_sr[9:6];
        cmd.gain     = data_sr[13:10];
        cmd.q        = data_sr[16:14];
        band_bad     = 1'b0;
        unique case (bsel)
            3'b010:  begin cmd.band = BAND_W'(0); cmd.shelf = 1'b0; end
            3'b011:  begin cmd.band = BAND_W'(0); cmd.shelf = 1'b1; end
            3'b100:  cmd.band = BAND_W'(1);
            3'b101:  cmd.band = BAND_W'(2);
            3'b110:  cmd.band = BAND_W'(3);
            3'b111:  band_bad = 1'b1;
            default: ;
        endcase
    end

    assign fields_ok = cmd.dbl_only ||
                       (!band_bad &&
                        (cmd.freq <= FREQ_W'(FREQ_MAX)) &&
                        (cmd.gain <= GAIN_W'(GAIN_MAX)));

    // outputs
    always_comb begin
        wr_en = 1'b0;
        if (state_q == COMMIT)
            wr_en = addr_ok_q && (cnt_q == CNT_W'(DATA_BITS)) && fields_ok;
    end

endmodule

// File: rtl/eq_ctl_bank.sv
module eq_ctl_bank
    import eq_ctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  eq_cmd_t                            cmd,
    output logic [NUM_CH*NUM_BAND*FREQ_W-1:0]  freq_o,
    output logic [NUM_CH*NUM_BAND*GAIN_W-1:0]  gain_o,
    output logic [NUM_CH*NUM_BAND*Q_W-1:0]     q_o,
    output logic [NUM_CH-1:0]                  shelf_o,
    output logic                               dbl_o
);

    logic band_wr;
    assign band_wr = wr_en && !cmd.dbl_only;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar b = 0; b < NUM_BAND; b++) begin : g_band
            localparam int IDX = c * NUM_BAND + b;
            logic [FREQ_W-1:0] freq_q;
            logic [GAIN_W-1:0] gain_q;
            logic [Q_W-1:0]    q_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    freq_q <= '0;
                    gain_q <= GAIN_W'(GAIN_FLAT);
                    q_q    <= '0;
                end else if (band_wr && cmd.ch[c] && (cmd.band == BAND_W'(b))) begin
                    freq_q <= cmd.freq;
                    gain_q <= cmd.gain;
                    q_q    <= cmd.q;
                end
            end
            assign freq_o[IDX*FREQ_W +: FREQ_W] = freq_q;
            assign gain_o[IDX*GAIN_W +: GAIN_W] = gain_q;
            assign q_o[IDX*Q_W +: Q_W]          = q_q;
        end

        logic shelf_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shelf_q <= 1'b0;
            else if (band_wr && cmd.ch[c] && (cmd.band == '0))
                shelf_q <= cmd.shelf;
        end
        assign shelf_o[c] = shelf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dbl_o <= 1'b0;
        else if (wr_en) dbl_o <= cmd.dbl;
    end

endmodule

// File: rtl/eq_ctl_top.sv
module eq_ctl_top
    import eq_ctl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h82
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_i,
    input  logic        sclk_i,
    input  logic        sdi_i,
    output logic [31:0] freq_o,
    output logic [31:0] gain_o,
    output logic [23:0] q_o,
    output logic [1:0]  shelf_o,
    output logic        dbl_o
);

    logic [2:0] sync_v;
    logic       ce_s;
    logic       wr_en;
    eq_cmd_t    cmd;

    eq_ctl_sync #(.LINES(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sclk_i, ce_i}),
        .sync_o  (sync_v)
    );

    assign ce_s = sync_v[0];

    eq_ctl_deframer #(.DEV_ADDR(DEV_ADDR)) u_defr (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce_s),
        .sclk  (sync_v[1]),
        .sdi   (sync_v[2]),
        .wr_en (wr_en),
        .cmd   (cmd)
    );

    eq_ctl_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .cmd     (cmd),
        .freq_o  (freq_o),
        .gain_o  (gain_o),
        .q_o     (q_o),
        .shelf_o (shelf_o),
        .dbl_o   (dbl_o)
    );

endmodule

// File: rtl/eq_ctl_checker.sv
module eq_ctl_checker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_lvl,
    input  logic        wr_en,
    input  logic [31:0] freq_o,
    input  logic [31:0] gain_o,
    input  logic [23:0] q_o,
    input  logic [1:0]  shelf_o,
    input  logic        dbl_o
);

    // R2: settings move only in the cycle after a commit
    a_r2_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(freq_o) && $stable(gain_o) && $stable(q_o) && $stable(shelf_o)));

    // R2: a commit happens only with the strobe already low
    a_r2_commit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ce_lvl);

    // R2: one frame gives at most a single write pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R9: doubling flag changes only through an accepted frame
    a_r9_dbl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(dbl_o));

    // R8: stored codes always lie inside their legal ranges
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 8; i++) begin
                a_r8_freq_range: assert (freq_o[i*4 +: 4] <= 4'd10);
                a_r8_gain_range: assert (gain_o[i*4 +: 4] <= 4'd12);
            end
        end
    end

endmodule

bind eq_ctl_top eq_ctl_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_lvl  (ce_s),
    .wr_en   (wr_en),
    .freq_o  (freq_o),
    .gain_o  (gain_o),
    .q_o     (q_o),
    .shelf_o (shelf_o),
    .dbl_o   (dbl_o)
);

// File: tb/eq_ctl_top_bench.sv
module eq_ctl_top_bench;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] ADDR       = 8'h82;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic [31:0] freq_o, gain_o;
    logic [23:0] q_o;
    logic [1:0]  shelf_o;
    logic        dbl_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0] m_freq [2][4];
    logic [3:0] m_gain [2][4];
    logic [2:0] m_q    [2][4];
    logic       m_shelf[2];
    logic       m_dbl;

    always #(CLK_PERIOD/2) clk = ~clk;

    eq_ctl_top #(.DEV_ADDR(ADDR)) u_eq_ctl_top (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
        .freq_o(freq_o), .gain_o(gain_o), .q_o(q_o), .shelf_o(shelf_o), .dbl_o(dbl_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [31:0] ef, eg;
        logic [23:0] eq;
        logic [1:0]  es;
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 4; b++) begin
                ef[(c*4+b)*4 +: 4] = m_freq[c][b];
                eg[(c*4+b)*4 +: 4] = m_gain[c][b];
                eq[(c*4+b)*3 +: 3] = m_q[c][b];
            end
            es[c] = m_shelf[c];
        end
        chk(req, "freq",  freq_o, ef);
        chk(req, "gain",  gain_o, eg);
        chk(req, "q",     {8'h0, q_o}, {8'h0, eq});
        chk(req, "shelf", {30'h0, shelf_o}, {30'h0, es});
        chk(req, "dbl",   {31'h0, dbl_o}, {31'h0, m_dbl});
    endtask

    // data word: {D19:D17=0, Q, gain, freq, band, channel, doubling}
    function automatic logic [19:0] mk(input logic dbl, input logic [1:0] ch, input logic [2:0] bs,
                                       input logic [3:0] f, input logic [3:0] g, input logic [2:0] q);
        return {3'b000, q, g, f, bs, ch, dbl};
    endfunction

    // bench model of a write, per the requirements
    task automatic model_wr(input logic [1:0] ch, input int band, input logic shelf,
                            input logic [3:0] f, input logic [3:0] g, input logic [2:0] q, input logic dbl);
        for (int c = 0; c < 2; c++) begin
            if (ch[c]) begin
                m_freq[c][band] = f;
                m_gain[c][band] = g;
                m_q[c][band]    = q;
                if (band == 0) m_shelf[c] = shelf;
            end
        end
        m_dbl = dbl;
    endtask

    task automatic sbit(input logic b);
        sdi = b;
        tick(4);
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
        tick(4);
    endtask

    task automatic open_frame(input logic [7:0] a, input logic [19:0] d, input int n);
        for (int i = 0; i < 8; i++) sbit(a[i]);
        tick(4);
        ce = 1'b1;
        tick(4);
        for (int i = 0; i < n; i++) sbit((i < 20) ? d[i] : 1'b0);
        tick(4);
    endtask

    task automatic close_frame();
        ce = 1'b0;
        tick(10);
    endtask

    task automatic send(input logic [7:0] a, input logic [19:0] d, input int n);
        open_frame(a, d, n);
        close_frame();
    endtask

    task automatic t_reset();
        for (int c = 0; c < 2; c++) begin
            for (int b = 0; b < 4; b++) begin
                m_freq[c][b] = 4'd0;
                m_gain[c][b] = 4'd6;
                m_q[c][b]    = 3'd0;
            end
            m_shelf[c] = 1'b0;
        end
        m_dbl = 1'b0;
        check_all("R1 reset");
    endtask

    task automatic t_left_lowmid();
        open_frame(ADDR, mk(1'b0, 2'b01, 3'b100, 4'd5, 4'd9, 3'd3), 20);
        check_all("R2 before strobe fall");
        close_frame();
        model_wr(2'b01, 1, 1'b0, 4'd5, 4'd9, 3'd3, 1'b0);
        check_all("R7 R5 left low-mid write");
    endtask

    task automatic t_both_high();
        send(ADDR, mk(1'b0, 2'b11, 3'b110, 4'd10, 4'd12, 3'd7), 20);
        model_wr(2'b11, 3, 1'b0, 4'd10, 4'd12, 3'd7, 1'b0);
        check_all("R5 R7 both channels high band, max codes");
        send(ADDR, mk(1'b0, 2'b10, 3'b101, 4'd1, 4'd0, 3'd2), 20);
        model_wr(2'b10, 2, 1'b0, 4'd1, 4'd0, 3'd2, 1'b0);
        check_all("R5 right high-mid only");
    endtask

    task automatic t_shelf();
        send(ADDR, mk(1'b0, 2'b10, 3'b011, 4'd2, 4'd0, 3'd1), 20);
        model_wr(2'b10, 0, 1'b1, 4'd2, 4'd0, 3'd1, 1'b0);
        check_all("R6 right low shelving");
        send(ADDR, mk(1'b0, 2'b11, 3'b011, 4'd4, 4'd8, 3'd5), 20);
        model_wr(2'b11, 0, 1'b1, 4'd4, 4'd8, 3'd5, 1'b0);
        check_all("R6 both low shelving");
        send(ADDR, mk(1'b0, 2'b01, 3'b010, 4'd3, 4'd7, 3'd6), 20);
        model_wr(2'b01, 0, 1'b0, 4'd3, 4'd7, 3'd6, 1'b0);
        check_all("R6 left back to peaking");
    endtask

    task automatic t_bad_addr();
        send(ADDR ^ 8'h01, mk(1'b1, 2'b11, 3'b100, 4'd7, 4'd1, 3'd4), 20);
        check_all("R3 address LSB mismatch");
        send(ADDR ^ 8'h80, mk(1'b1, 2'b11, 3'b100, 4'd7, 4'd1, 3'd4), 20);
        check_all("R3 address MSB mismatch");
    endtask

    task automatic t_bit_count();
        send(ADDR, mk(1'b1, 2'b11, 3'b110, 4'd6, 4'd2, 3'd1), 19);
        check_all("R4 19 data bits");
        send(ADDR, mk(1'b1, 2'b11, 3'b110, 4'd6, 4'd2, 3'd1), 21);
        check_all("R4 21 data bits");
    endtask

    task automatic t_range();
        send(ADDR, mk(1'b1, 2'b01, 3'b100, 4'd11, 4'd6, 3'd0), 20);
        check_all("R8 frequency code 11");
        send(ADDR, mk(1'b1, 2'b10, 3'b010, 4'd0, 4'd13, 3'd0), 20);
        check_all("R8 gain code 13");
    endtask

    task automatic t_reserved();
        send(ADDR, mk(1'b1, 2'b11, 3'b111, 4'd2, 4'd3, 3'd4), 20);
        check_all("R10 reserved band code");
    endtask

    task automatic t_dbl();
        send(ADDR, mk(1'b1, 2'b11, 3'b001, 4'd15, 4'd15, 3'd7), 20);
        m_dbl = 1'b1;
        check_all("R9 doubling only, other bits ignored");
        send(ADDR, mk(1'b1, 2'b00, 3'b010, 4'd9, 4'd9, 3'd2), 20);
        check_all("R5 no channel selected");
        send(ADDR, mk(1'b0, 2'b01, 3'b110, 4'd8, 4'd11, 3'd0), 20);
        model_wr(2'b01, 3, 1'b0, 4'd8, 4'd11, 3'd0, 1'b0);
        check_all("R9 band frame clears doubling");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_left_lowmid();
        t_both_high();
        t_shelf();
        t_bad_addr();
        t_bit_count();
        t_range();
        t_reserved();
        t_dbl();
        finish_run();
    end

endmodule